// File: doc/BRIEF.md
# Data Bus Tenure Master Controller

This block runs the master side of one data-bus tenure for a transaction whose address phase has already been won. A requester hands it a read or write, as a single beat or a four-beat burst. The block then watches the shared bus until it holds a qualified data grant. That grant exists only while the grant line is high and the bus-busy, data-retry and address-retry lines are all low. The address-retry input carries only retries for the address phase tied to this transaction.

Once it owns the bus, the block drives the bus-busy indication. On a write it enables the data output drivers. On a read it pulses a capture strobe for each accepted beat. Every beat needs a transfer acknowledge. An acknowledge that arrives together with data retry is discarded, so that beat is repeated. The tenure ends on the accepted acknowledge of the last beat. In the next cycle the block releases busy and the output enable, sends a one-cycle done pulse with the direction, and returns to idle to accept another request.

Top module: `dbtm_master`

## Requirements
- R1: After reset the block is idle: `req_ready`=1, `busy_drive`=0, `data_oe`=0, `cap_strobe`=0, `done`=0, `beat_num`=0.
- R2: While waiting for the bus, the block takes ownership (`busy_drive` becomes 1 at the next clock edge) only when `bus_grant`=1 and `bus_busy_in`, `data_retry` and `addr_retry` are all 0 in the same cycle. Every other combination leaves it waiting.
- R3: `busy_drive` stays 1 in every cycle from the one after the qualified grant through the cycle of the final accepted acknowledge. It is 0 in all other cycles.
- R4: When `req_burst`=0, the first accepted acknowledge (`xfer_ack`=1, `data_retry`=0) ends the tenure.
- R5: When `req_burst`=1, exactly four accepted acknowledges are needed. `beat_num` gives the current beat (0..3) and advances by one after each accepted non-final acknowledge.
- R6: An acknowledge with `data_retry`=1 is not counted and produces no capture strobe. `beat_num` keeps its value and the same beat is repeated.
- R7: `data_oe` is 1 exactly while the block owns the bus for a write (`req_write`=1). It is 0 for reads, and it is cleared in the cycle after the final acknowledge.
- R8: `cap_strobe` is 1 only in a read-tenure cycle that has an accepted acknowledge. It is never 1 in a write tenure.
- R9: `done` is a one-cycle pulse in the cycle after the final acknowledge. `done_write` then equals the latched `req_write`.
- R10: `req_ready` is 1 only when idle. A `req_valid` raised while the block is busy is ignored and does not start another tenure.
- R11: `xfer_ack` is ignored while the block does not own the bus. It neither advances `beat_num` nor raises `cap_strobe`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Start a tenure (taken only when idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_burst | input | 1 | 1 = four-beat burst, 0 = single beat |
| req_ready | output | 1 | Block is idle and can take a request |
| bus_grant | input | 1 | Data-bus grant from the arbiter |
| bus_busy_in | input | 1 | Data bus seen busy by another master |
| data_retry | input | 1 | Data retry |
| addr_retry | input | 1 | Address retry for the associated address phase |
| xfer_ack | input | 1 | Per-beat transfer acknowledge |
| busy_drive | output | 1 | Block owns the data bus and asserts busy |
| data_oe | output | 1 | Data output enable (writes) |
| cap_strobe | output | 1 | Capture read data this cycle |
| beat_num | output | CNT_W | Current beat index |
| done | output | 1 | Tenure finished (one cycle) |
| done_write | output | 1 | Direction of the finished tenure |

## Verification
The bench walks all sixteen grant, busy, data-retry and address-retry combinations while the block waits. It holds the acknowledge high during that walk. A qualifier that ignores address retry would take the bus too early, and a counter that listens before ownership would skip beats. Every mix of direction, length, acknowledge stalls and a data retry on each beat position is then run. A design that counted a retried acknowledge would end a burst one beat early or strobe stale read data. Busy, output enable and done are checked in the cycle after the last beat, which catches an off-by-one release. A request raised in mid-tenure, followed by a qualified grant after completion, shows whether a stray request was latched.

// File: rtl/dbtm_pkg.sv
package dbtm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_OWN  = 2'd2
    } dbtm_state_e;

    typedef struct packed {
        dbtm_state_e state;
        logic        is_write;
        logic        is_burst;
        logic        done;
        logic        done_write;
    } dbtm_ctl_t;

endpackage

// File: rtl/dbtm_grant_qual.sv
module dbtm_grant_qual (
    input  logic armed,
    input  logic bus_grant,
    input  logic bus_busy_in,
    input  logic data_retry,
    input  logic addr_retry,
    output logic qualified
);
    // Grant counts only when no other party holds or retries the bus.
    always_comb begin
        qualified = armed & bus_grant & ~bus_busy_in & ~data_retry & ~addr_retry;
    end
endmodule

// File: rtl/dbtm_beat_ctr.sv
module dbtm_beat_ctr #(
    parameter  int BEATS = 4,
    localparam int CNT_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             adv,
    output logic [CNT_W-1:0] count,
    output logic             at_last
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BEATS - 1);

    logic [CNT_W-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (clr) begin
            count_d = '0;
        end else if (adv) begin
            count_d = count_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else begin
            count_q <= count_d;
        end
    end

    assign count   = count_q;
    assign at_last = (count_q == LAST);
endmodule

// File: rtl/dbtm_master.sv
module dbtm_master
    import dbtm_pkg::*;
#(
    parameter  int BURST_BEATS = 4,
    localparam int CNT_W = (BURST_BEATS > 1) ? $clog2(BURST_BEATS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             req_burst,
    output logic             req_ready,
    input  logic             bus_grant,
    input  logic             bus_busy_in,
    input  logic             data_retry,
    input  logic             addr_retry,
    input  logic             xfer_ack,
    output logic             busy_drive,
    output logic             data_oe,
    output logic             cap_strobe,
    output logic [CNT_W-1:0] beat_num,
    output logic             done,
    output logic             done_write
);
    dbtm_ctl_t ctl_d, ctl_q;

    logic owning;
    logic waiting;
    logic qualified;
    logic good_ack;
    logic at_last;
    logic final_ack;

    assign owning  = (ctl_q.state == ST_OWN);
    assign waiting = (ctl_q.state == ST_WAIT);

    dbtm_grant_qual u_qual (
        .armed       (waiting),
        .bus_grant   (bus_grant),
        .bus_busy_in (bus_busy_in),
        .data_retry  (data_retry),
        .addr_retry  (addr_retry),
        .qualified   (qualified)
    );

    // A beat is accepted only when acknowledged without data retry.
    assign good_ack  = owning & xfer_ack & ~data_retry;
    assign final_ack = good_ack & (~ctl_q.is_burst | at_last);

    dbtm_beat_ctr #(.BEATS(BURST_BEATS)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (final_ack | ~owning),
        .adv     (good_ack),
        .count   (beat_num),
        .at_last (at_last)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    ctl_d.state    = ST_WAIT;
                    ctl_d.is_write = req_write;
                    ctl_d.is_burst = req_burst;
                end
            end
            ST_WAIT: begin
                if (qualified) begin
                    ctl_d.state = ST_OWN;
                end
            end
            ST_OWN: begin
                if (final_ack) begin
                    ctl_d.state      = ST_IDLE;
                    ctl_d.done       = 1'b1;
                    ctl_d.done_write = ctl_q.is_write;
                end
            end
            default: begin
                ctl_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{state: ST_IDLE, is_write: 1'b0, is_burst: 1'b0,
                       done: 1'b0, done_write: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign req_ready  = (ctl_q.state == ST_IDLE);
    assign busy_drive = owning;
    assign data_oe    = owning & ctl_q.is_write;
    assign cap_strobe = good_ack & ~ctl_q.is_write;
    assign done       = ctl_q.done;
    assign done_write = ctl_q.done_write;
endmodule

// File: rtl/dbtm_master_chk.sv
module dbtm_master_chk #(
    parameter int CNT_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_grant,
    input logic             bus_busy_in,
    input logic             data_retry,
    input logic             addr_retry,
    input logic             xfer_ack,
    input logic             req_ready,
    input logic             busy_drive,
    input logic             data_oe,
    input logic             cap_strobe,
    input logic [CNT_W-1:0] beat_num,
    input logic             done
);
    p_qual_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_drive) |-> $past(bus_grant & ~bus_busy_in & ~data_retry & ~addr_retry));

    p_release_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_drive) |-> done);

    p_retry_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_drive && xfer_ack && data_retry) |=> (busy_drive && $stable(beat_num)));

    p_oe_owned_r7: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> busy_drive);

    p_strobe_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cap_strobe |-> (busy_drive && !data_oe && xfer_ack && !data_retry));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_ready_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !busy_drive);

    p_no_count_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_drive |-> (beat_num == '0));
endmodule

bind dbtm_master dbtm_master_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_grant   (bus_grant),
    .bus_busy_in (bus_busy_in),
    .data_retry  (data_retry),
    .addr_retry  (addr_retry),
    .xfer_ack    (xfer_ack),
    .req_ready   (req_ready),
    .busy_drive  (busy_drive),
    .data_oe     (data_oe),
    .cap_strobe  (cap_strobe),
    .beat_num    (beat_num),
    .done        (done)
);

// File: tb/dbtm_master_test.sv
`timescale 1ns/1ps
module dbtm_master_test;
    localparam int BEATS = 4;
    localparam int CW    = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 0, req_write = 0, req_burst = 0;
    logic bus_grant = 0, bus_busy_in = 0, data_retry = 0, addr_retry = 0, xfer_ack = 0;
    logic req_ready, busy_drive, data_oe, cap_strobe, done, done_write;
    logic [CW-1:0] beat_num;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    dbtm_master #(.BURST_BEATS(BEATS)) uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_burst(req_burst),
        .req_ready(req_ready),
        .bus_grant(bus_grant), .bus_busy_in(bus_busy_in),
        .data_retry(data_retry), .addr_retry(addr_retry), .xfer_ack(xfer_ack),
        .busy_drive(busy_drive), .data_oe(data_oe), .cap_strobe(cap_strobe),
        .beat_num(beat_num), .done(done), .done_write(done_write)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic clear_bus();
        bus_grant = 0; bus_busy_in = 0; data_retry = 0; addr_retry = 0; xfer_ack = 0;
    endtask

    // One full tenure. retry_beat < 0 means no retry; stall inserts a no-ack cycle per beat.
    task automatic tenure(input bit wr, input bit burst, input int retry_beat,
                          input bit stall, input bit sweep, input bit poke);
        int nb;
        nb = burst ? BEATS : 1;
        @(negedge clk);
        chk("R10 ready when idle", req_ready, 1);
        req_valid = 1; req_write = wr; req_burst = burst;
        @(negedge clk);
        req_valid = 0;
        chk("R10 not ready after request", req_ready, 0);
        chk("R3 no busy before grant", busy_drive, 0);
        if (sweep) begin
            for (int c = 0; c < 16; c++) begin
                if (c == 8) continue;
                {bus_grant, bus_busy_in, data_retry, addr_retry} = 4'(c);
                xfer_ack = 1;
                #1;
                chk("R11 no strobe while waiting", cap_strobe, 0);
                @(negedge clk);
                chk("R2 unqualified grant keeps waiting", busy_drive, 0);
                chk("R11 ack ignored while waiting", beat_num, 0);
            end
        end
        clear_bus();
        bus_grant = 1;
        @(negedge clk);
        clear_bus();
        chk("R2 qualified grant takes bus", busy_drive, 1);
        chk("R7 output enable follows direction", data_oe, wr);
        for (int b = 0; b < nb; b++) begin
            if (stall) begin
                xfer_ack = 0;
                #1;
                chk("R8 no strobe without ack", cap_strobe, 0);
                @(negedge clk);
                chk("R3 busy held through stall", busy_drive, 1);
                chk("R5 beat held through stall", beat_num, b);
            end
            if (retry_beat == b) begin
                xfer_ack = 1; data_retry = 1;
                req_valid = poke;
                #1;
                chk("R6 no strobe on retried ack", cap_strobe, 0);
                @(negedge clk);
                req_valid = 0;
                chk("R6 busy held after retry", busy_drive, 1);
                chk("R6 beat repeated after retry", beat_num, b);
            end
            xfer_ack = 1; data_retry = 0;
            #1;
            chk("R8 strobe on accepted read beat", cap_strobe, wr ? 0 : 1);
            chk("R7 output enable during beat", data_oe, wr);
            chk("R5 beat index", beat_num, b);
            chk("R9 no done during tenure", done, 0);
            @(negedge clk);
            xfer_ack = 0;
            if (b < nb - 1) begin
                chk("R5 busy held between burst beats", busy_drive, 1);
            end
        end
        chk(burst ? "R5 busy released after fourth beat" : "R4 busy released after single beat",
            busy_drive, 0);
        chk("R7 output enable removed", data_oe, 0);
        chk("R9 done pulse", done, 1);
        chk("R9 done direction", done_write, wr);
        chk("R10 ready after tenure", req_ready, 1);
        chk("R11 beat cleared", beat_num, 0);
        if (poke) begin
            bus_grant = 1;
            @(negedge clk);
            chk("R10 request during tenure ignored", busy_drive, 0);
            @(negedge clk);
            chk("R10 request during tenure ignored", busy_drive, 0);
            clear_bus();
        end else begin
            @(negedge clk);
        end
        chk("R9 done lasts one cycle", done, 0);
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #3;
        chk("R1 ready in reset", req_ready, 1);
        chk("R1 busy low in reset", busy_drive, 0);
        chk("R1 oe low in reset", data_oe, 0);
        chk("R1 done low in reset", done, 0);
        chk("R1 strobe low in reset", cap_strobe, 0);
        chk("R1 beat zero in reset", beat_num, 0);
        @(negedge clk); @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        tenure(1'b0, 1'b0, -1, 1'b0, 1'b1, 1'b0);
        tenure(1'b1, 1'b1, -1, 1'b0, 1'b1, 1'b1);
        for (int wr = 0; wr < 2; wr++)
            for (int bu = 0; bu < 2; bu++)
                for (int st = 0; st < 2; st++)
                    for (int rb = -1; rb < (bu ? BEATS : 1); rb++)
                        tenure(wr[0], bu[0], rb, st[0], 1'b0, (rb == 0) ? 1'b1 : 1'b0);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule